// File: doc/BRIEF.md
# Byte-Lane Pseudo-SRAM Access Controller

This block sits between a synchronous host and an asynchronous pseudo-SRAM device. It is DRAM-based, but it behaves like a static RAM because it refreshes itself. The host side is two valid/ready streams:

- A request stream carries an address, a write flag, per-byte enables and write data.
- A response stream returns one word for every request. For a write that word is zero. For a read it holds the enabled bytes.

Each accepted request becomes one complete read or write cycle on the device pins. Its length is a whole number of clock cycles, set by parameters. Write cycles are timed by the write strobe.

Two rules come from the device's self-refresh and from its shared data bus.

- **Chip-select cap.** The device's hidden refresh depends on chip select not staying low indefinitely. A counter watches how long chip select has been low. Once it nears the limit, the block forces chip select high for a rest period before it starts the next cycle. Between those forced releases, chip select stays low across back-to-back accesses.
- **Bus direction.** The controller never drives the data bus while the device drives it. After every read there is at least one cycle with output enable high before write data appears.

Back-pressure works as follows:

- `req_ready` is high only when the controller is idle and the chip-select rest period is over.
- A request transfers on a cycle with `req_valid` and `req_ready` both high.
- `rsp_valid` then stays high, with `rsp_rdata` unchanged, until the host takes it with `rsp_ready`.
- No new request is accepted until that response has been taken.

Top module: `psram_access_ctrl`

## Requirements
- R1: After reset, chip select, output enable, write strobe and both lane strobes are high, the data bus is not driven, `req_ready` is high and `rsp_valid` is low.
- R2: A request is accepted only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the response has been taken. `rsp_valid` holds with stable `rsp_rdata` until a cycle with `rsp_ready` high, and drops on the next cycle.
- R3: A read holds chip select low, output enable low and the write strobe high for exactly RD_CYC cycles. The bus is sampled at the end of the last of those cycles. In `rsp_rdata`, enable bit 0 selects bits 7:0 and enable bit 1 selects bits 15:8. A disabled byte reads as zero.
- R4: A write keeps output enable high and drives the data bus for WR_LEAD+WR_PULSE+WR_TAIL cycles. The write strobe is low for exactly WR_PULSE cycles, starting after WR_LEAD cycles. Only the bytes whose enable bit is set change in the device.
- R5: Lane strobe i (bit 0 = low byte, bit 1 = high byte) is low exactly during the cycles of a read or write whose enable bit i is set. All selected lanes switch on the same clock edge.
- R6: The address and lane strobes do not change during a read or write cycle.
- R7: The data bus is never driven while output enable is low. The bus output enable never rises in the cycle right after a cycle with output enable low.
- R8: Whenever chip select is high, output enable, write strobe and both lane strobes are high and the data bus is not driven.
- R9: Chip select is never low for more than CS_MAX_CYC consecutive cycles, even while idle. It stays high for at least GAP_CYC cycles before it falls again.
- R10: A request with byte enable 2'b00 completes with a zero response. It produces no output-enable, write-strobe or lane-strobe activity and no falling edge of chip select, and it leaves the device contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (20) | Word address |
| req_be | input | LANES (2) | Byte enables, bit 0 = low byte |
| req_wdata | input | DATA_W (16) | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with valid |
| rsp_rdata | output | DATA_W (16) | Read data; zero for writes and disabled bytes |
| mem_addr | output | ADDR_W (20) | Device address |
| mem_cs_n | output | 1 | Device chip select, low active |
| mem_oe_n | output | 1 | Device output enable, low active |
| mem_we_n | output | 1 | Device write strobe, low active |
| mem_lane_n | output | LANES (2) | Lane strobes, bit 0 = low byte, low active |
| mem_dq_o | output | DATA_W (16) | Data bus output value |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_i | input | DATA_W (16) | Data bus input value |

## Verification
A phase counter that is off by one shows at the pins within a single access, as a strobe window one cycle too long or too short. On reads it also shows as data captured before the device model presents valid bytes. A byte-lane mix-up in the held enables shows up as corrupted neighbour bytes the next time the full word is read back. A chip-select counter that never saturates or never clears shows as a low run longer than the cap during a back-to-back burst, or during a long idle stretch. A missing rest check shows as a rest gap shorter than GAP_CYC cycles at the next access.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_RESP
  } acc_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_lane_map.sv
module psram_lane_map #(
  parameter int LANES = 2
) (
  input  logic                 active,
  input  logic [LANES-1:0]     strobe_be,
  output logic [LANES-1:0]     lane_n,
  input  logic [LANES-1:0]     keep_be,
  input  logic [LANES*8-1:0]   raw,
  output logic [LANES*8-1:0]   kept
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // strobe low only while an access is running and the lane is enabled
    assign lane_n[g]        = !(active && strobe_be[g]);
    // disabled lanes never pass bus data back to the host
    assign kept[g*8 +: 8]   = keep_be[g] ? raw[g*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/psram_cs_guard.sv
module psram_cs_guard #(
  parameter int CS_MAX_CYC  = 1600,
  parameter int GAP_CYC     = 2,
  parameter int ACC_MAX_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic near_limit,
  output logic resting
);

  localparam int CNT_W = $clog2(CS_MAX_CYC + 1);
  localparam int RST_W = $clog2(GAP_CYC + 1);
  // headroom: one full access plus the response cycle plus the release edge
  localparam int LIMIT = CS_MAX_CYC - ACC_MAX_CYC - 2;

  logic [CNT_W-1:0] low_cnt;
  logic [RST_W-1:0] rest_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      rest_cnt <= RST_W'(GAP_CYC);
    end else begin
      if (cs_n) begin
        low_cnt <= '0;
        if (rest_cnt < RST_W'(GAP_CYC)) rest_cnt <= rest_cnt + 1'b1;
      end else begin
        rest_cnt <= '0;
        if (low_cnt != {CNT_W{1'b1}}) low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  assign near_limit = !cs_n && (low_cnt >= CNT_W'(LIMIT));
  assign resting    = cs_n && (rest_cnt < RST_W'(GAP_CYC));

  // R9: the low run seen on the pin never reaches the cap
  assert_cs_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (low_cnt < CNT_W'(CS_MAX_CYC)))
    else $error("chip select low beyond cap");

  // R9: chip select falls only after a full rest period
  assert_cs_rest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(rest_cnt) >= RST_W'(GAP_CYC)))
    else $error("chip select fell before rest done");

endmodule

// File: rtl/psram_access_ctrl.sv
module psram_access_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int RD_CYC     = 4,
  parameter int WR_LEAD    = 1,
  parameter int WR_PULSE   = 3,
  parameter int WR_TAIL    = 1,
  parameter int GAP_CYC    = 2,
  parameter int CS_MAX_CYC = 1600
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W/8-1:0]    req_be,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_cs_n,
  output logic                   mem_oe_n,
  output logic                   mem_we_n,
  output logic [DATA_W/8-1:0]    mem_lane_n,
  output logic [DATA_W-1:0]      mem_dq_o,
  output logic                   mem_dq_oe,
  input  logic [DATA_W-1:0]      mem_dq_i
);

  localparam int LANES   = DATA_W / 8;
  localparam int WR_TOT  = WR_LEAD + WR_PULSE + WR_TAIL;
  localparam int ACC_MAX = imax(RD_CYC, WR_TOT);
  localparam int PH_W    = $clog2(ACC_MAX + 1);
  localparam logic [PH_W-1:0] RD_LAST = PH_W'(RD_CYC - 1);
  localparam logic [PH_W-1:0] WR_LAST = PH_W'(WR_TOT - 1);
  localparam logic [PH_W-1:0] WE_ON   = PH_W'(WR_LEAD);
  localparam logic [PH_W-1:0] WE_OFF  = PH_W'(WR_LEAD + WR_PULSE);

  acc_state_e        state, state_d;
  logic [PH_W-1:0]   phase, phase_d;
  logic              cs_n_q, cs_n_d;
  logic              oe_n_q, we_n_q, dq_oe_q;
  logic [LANES-1:0]  lane_n_q, lane_n_d;
  logic [ADDR_W-1:0] h_addr;
  logic [LANES-1:0]  h_be;
  logic [DATA_W-1:0] h_wdata;
  logic [DATA_W-1:0] rdata_q, kept;
  logic              load, capture;
  logic              near_limit, resting;
  logic              active_d;
  logic [LANES-1:0]  be_d;

  psram_cs_guard #(
    .CS_MAX_CYC (CS_MAX_CYC),
    .GAP_CYC    (GAP_CYC),
    .ACC_MAX_CYC(ACC_MAX)
  ) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n_q),
    .near_limit(near_limit),
    .resting   (resting)
  );

  assign active_d = (state_d == ST_READ) || (state_d == ST_WRITE);
  assign be_d     = load ? req_be : h_be;

  psram_lane_map #(.LANES(LANES)) u_lanes (
    .active   (active_d),
    .strobe_be(be_d),
    .lane_n   (lane_n_d),
    .keep_be  (h_be),
    .raw      (mem_dq_i),
    .kept     (kept)
  );

  assign req_ready = (state == ST_IDLE) && !resting && !near_limit;

  always_comb begin
    state_d = state;
    phase_d = phase;
    cs_n_d  = cs_n_q;
    load    = 1'b0;
    capture = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (near_limit) cs_n_d = 1'b1;
        if (req_valid && req_ready) begin
          load = 1'b1;
          if (req_be == '0) begin
            state_d = ST_RESP;
          end else begin
            state_d = req_write ? ST_WRITE : ST_READ;
            phase_d = '0;
            cs_n_d  = 1'b0;
          end
        end
      end
      ST_READ: begin
        if (phase == RD_LAST) begin
          capture = 1'b1;
          state_d = ST_RESP;
          phase_d = '0;
        end else begin
          phase_d = phase + 1'b1;
        end
      end
      ST_WRITE: begin
        if (phase == WR_LAST) begin
          state_d = ST_RESP;
          phase_d = '0;
        end else begin
          phase_d = phase + 1'b1;
        end
      end
      ST_RESP: begin
        if (near_limit) cs_n_d = 1'b1;
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= '0;
      cs_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      we_n_q   <= 1'b1;
      dq_oe_q  <= 1'b0;
      lane_n_q <= '1;
      h_addr   <= '0;
      h_be     <= '0;
      h_wdata  <= '0;
      rdata_q  <= '0;
    end else begin
      state    <= state_d;
      phase    <= phase_d;
      cs_n_q   <= cs_n_d;
      oe_n_q   <= !(state_d == ST_READ);
      we_n_q   <= !((state_d == ST_WRITE) && (phase_d >= WE_ON) && (phase_d < WE_OFF));
      dq_oe_q  <= (state_d == ST_WRITE);
      lane_n_q <= lane_n_d;
      if (load) begin
        h_addr  <= req_addr;
        h_be    <= req_be;
        h_wdata <= req_wdata;
        rdata_q <= '0;
      end
      if (capture) rdata_q <= kept;
    end
  end

  assign mem_addr   = h_addr;
  assign mem_cs_n   = cs_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_lane_n = lane_n_q;
  assign mem_dq_o   = h_wdata;
  assign mem_dq_oe  = dq_oe_q;
  assign rsp_valid  = (state == ST_RESP);
  assign rsp_rdata  = rdata_q;

  assert_no_drive_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n)
    else $error("bus driven while device output enabled");

  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n))
    else $error("no turnaround before write drive");

  assert_standby_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_oe_n && mem_we_n && (mem_lane_n == '1) && !mem_dq_oe))
    else $error("activity while deselected");

  assert_read_write_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n))
    else $error("output enable and write strobe both low");

  assert_lane_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lane_n != '1) |-> (!mem_oe_n || mem_dq_oe))
    else $error("lane strobe outside an access");

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((!mem_oe_n || mem_dq_oe) && $past(!mem_oe_n || mem_dq_oe))
      |-> ($stable(mem_addr) && $stable(mem_lane_n)))
    else $error("address or lanes moved mid-access");

  assert_rsp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)))
    else $error("response dropped or changed under back-pressure");

endmodule

// File: tb/tb_psram_access_ctrl.sv
module tb_psram_access_ctrl;

  localparam int AW    = 4;
  localparam int DW    = 16;
  localparam int L     = 2;
  localparam int RD    = 4;
  localparam int LEAD  = 1;
  localparam int PULSE = 3;
  localparam int TAIL  = 1;
  localparam int GAP   = 2;
  localparam int CSMAX = 40;
  localparam int WORDS = 1 << AW;

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [L-1:0]  req_be;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid, rsp_ready;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [L-1:0]  mem_lane_n;
  logic [DW-1:0] mem_dq_o, mem_dq_i;

  psram_access_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD), .WR_LEAD(LEAD), .WR_PULSE(PULSE),
    .WR_TAIL(TAIL), .GAP_CYC(GAP), .CS_MAX_CYC(CSMAX)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0;
  int rel_cnt = 0;
  int cyc = 0;
  bit noop_window = 0;

  // device model: data valid only after the output enable has been low long enough
  logic [DW-1:0] pmem [WORDS];
  int oe_cnt;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) pmem[i] <= DW'(i * 16'h0101 ^ 16'h3C00);
      oe_cnt <= 0;
    end else begin
      if (!mem_cs_n && !mem_oe_n) oe_cnt <= oe_cnt + 1; else oe_cnt <= 0;
      if (!mem_cs_n && !mem_we_n && mem_dq_oe)
        for (int g = 0; g < L; g++)
          if (!mem_lane_n[g]) pmem[mem_addr][g*8 +: 8] <= mem_dq_o[g*8 +: 8];
    end
  end

  always_comb begin
    for (int g = 0; g < L; g++)
      mem_dq_i[g*8 +: 8] = (!mem_cs_n && !mem_oe_n && !mem_lane_n[g] && oe_cnt >= RD)
                           ? pmem[mem_addr][g*8 +: 8] : 8'hA5;
  end

  // pin-level protocol monitor
  logic          p_cs_n = 1, p_oe_n = 1, p_we_n = 1, p_dq_oe = 0;
  logic [AW-1:0] p_addr = '0;
  logic [L-1:0]  p_lane = '1;
  int cs_low_run = 0, cs_high_run = 1000, we_low_run = 0, oe_low_run = 0;

  task automatic mfail(input string tag, input int act, input int exp);
    mon_errors++;
    $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      mon_checks++;
      if (mem_dq_oe && !mem_oe_n) mfail("R7 drive during read", 1, 0);
      if (mem_dq_oe && !p_dq_oe && !p_oe_n) mfail("R7 turnaround", 0, 1);
      if (mem_cs_n && (!mem_oe_n || !mem_we_n || mem_lane_n != '1 || mem_dq_oe))
        mfail("R8 standby quiet", 1, 0);
      if ((mem_lane_n != '1) != (!mem_oe_n || mem_dq_oe)) mfail("R5 lane window", 1, 0);
      if (!mem_oe_n && !mem_we_n) mfail("R3 oe/we overlap", 1, 0);
      if ((!mem_oe_n || mem_dq_oe) && (!p_oe_n || p_dq_oe) &&
          (mem_addr != p_addr || mem_lane_n != p_lane))
        mfail("R6 address/lane stable", int'(mem_addr), int'(p_addr));
      if (!mem_cs_n && p_cs_n && cs_high_run < GAP) mfail("R9 rest gap", cs_high_run, GAP);
      if (mem_cs_n && !p_cs_n) rel_cnt++;
      if (!mem_cs_n) begin cs_low_run++; cs_high_run = 0; end
      else begin cs_low_run = 0; cs_high_run++; end
      if (cs_low_run > CSMAX) mfail("R9 cs cap", cs_low_run, CSMAX);
      if (!mem_we_n) we_low_run++;
      else begin
        if (!p_we_n && we_low_run != PULSE) mfail("R4 write pulse", we_low_run, PULSE);
        we_low_run = 0;
      end
      if (!mem_oe_n) oe_low_run++;
      else begin
        if (!p_oe_n && oe_low_run != RD) mfail("R3 read window", oe_low_run, RD);
        oe_low_run = 0;
      end
      if (noop_window && ((!mem_cs_n && p_cs_n) || !mem_oe_n || !mem_we_n ||
                          mem_lane_n != '1 || mem_dq_oe))
        mfail("R10 noop activity", 1, 0);
      p_cs_n = mem_cs_n; p_oe_n = mem_oe_n; p_we_n = mem_we_n;
      p_dq_oe = mem_dq_oe; p_addr = mem_addr; p_lane = mem_lane_n;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors + mon_errors + 1,
               checks + mon_checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [L-1:0] be,
                        input logic [DW-1:0] wd, input int stall,
                        output logic [DW-1:0] rd);
    logic [DW-1:0] held;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 ready low after accept", 32'(req_ready), 0);
    while (!rsp_valid) @(negedge clk);
    held = rsp_rdata;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == held && !req_ready, "R2 response held",
          32'(rsp_rdata), 32'(held));
    end
    rd = rsp_rdata;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid, "R2 response drops after take", 32'(rsp_valid), 0);
  endtask

  logic [DW-1:0] ref_mem [WORDS];

  function automatic logic [DW-1:0] masked(input logic [DW-1:0] w, input logic [L-1:0] be);
    logic [DW-1:0] r;
    for (int g = 0; g < L; g++) r[g*8 +: 8] = be[g] ? w[g*8 +: 8] : 8'h00;
    return r;
  endfunction

  initial begin
    logic [DW-1:0] rd, wd, exp;
    int rel0;
    req_valid = 0; req_write = 0; req_addr = '0; req_be = '0; req_wdata = '0;
    rsp_ready = 0;
    for (int i = 0; i < WORDS; i++) ref_mem[i] = DW'(i * 16'h0101 ^ 16'h3C00);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(mem_cs_n && mem_oe_n && mem_we_n && mem_lane_n == '1 && !mem_dq_oe,
        "R1 pins idle", {27'(0), mem_cs_n, mem_oe_n, mem_we_n, mem_lane_n}, 32'h1F);
    chk(req_ready && !rsp_valid, "R1 handshake idle", {30'(0), req_ready, rsp_valid}, 2);

    // R4 write sweep over every address and nonzero enable, full-word readback
    for (int a = 0; a < WORDS; a++) begin
      for (int b = 1; b < 4; b++) begin
        wd = DW'(a * 16'h1357 + b * 16'h0F0F + 16'h0042);
        do_req(1'b1, AW'(a), L'(b), wd, 0, rd);
        chk(rd == '0, "R4 write response zero", 32'(rd), 0);
        for (int g = 0; g < L; g++) if (b[g]) ref_mem[a][g*8 +: 8] = wd[g*8 +: 8];
        do_req(1'b0, AW'(a), 2'b11, '0, 0, rd);
        chk(rd == ref_mem[a], "R4 lane write readback", 32'(rd), 32'(ref_mem[a]));
      end
    end

    // R3 read sweep over every address and enable (enable 00 covers R10)
    for (int a = 0; a < WORDS; a++) begin
      for (int b = 0; b < 4; b++) begin
        do_req(1'b0, AW'(a), L'(b), '0, 0, rd);
        exp = masked(ref_mem[a], L'(b));
        chk(rd == exp, (b == 0) ? "R10 empty read zero" : "R3 lane read", 32'(rd), 32'(exp));
      end
    end

    // R10 empty-enable write leaves contents unchanged, no strobes
    noop_window = 1;
    do_req(1'b1, AW'(5), 2'b00, 16'hFFFF, 0, rd);
    noop_window = 0;
    chk(rd == '0, "R10 noop response", 32'(rd), 0);
    do_req(1'b0, AW'(5), 2'b11, '0, 0, rd);
    chk(rd == ref_mem[5], "R10 contents kept", 32'(rd), 32'(ref_mem[5]));

    // R2 back-pressure on response
    do_req(1'b0, AW'(9), 2'b11, '0, 6, rd);
    chk(rd == ref_mem[9], "R2 data after stall", 32'(rd), 32'(ref_mem[9]));

    // R9 back-to-back burst must be broken up by forced releases
    rel0 = rel_cnt;
    for (int k = 0; k < 30; k++) begin
      do_req(1'b0, AW'(k % WORDS), 2'b11, '0, 0, rd);
      chk(rd == ref_mem[k % WORDS], "R9 burst read", 32'(rd), 32'(ref_mem[k % WORDS]));
    end
    chk(rel_cnt > rel0, "R9 forced release in burst", 32'(rel_cnt - rel0), 1);

    // R9 cap also applies while idle
    do_req(1'b0, AW'(3), 2'b01, '0, 0, rd);
    repeat (CSMAX + 10) @(negedge clk);
    chk(mem_cs_n == 1'b1, "R9 idle release", 32'(mem_cs_n), 1);

    $display("Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks);
    $finish;
  end

endmodule